// File: doc/BRIEF.md
# Receive FIFO with Programmable Trigger Level

This block is the receive half of a byte-oriented serial controller. Bytes arriving from a bit-level receiver (not part of this block) are offered on a one-cycle strobe. While reception is enabled, each byte is written into a 16-entry ring buffer. Software drains the buffer by reading a data offset and can read the current fill count at a second offset. Both come through a small register port.

A receive-ready flag is raised when the fill count reaches a programmable threshold. The threshold is one of four levels, picked by a two-bit field in a buffer control register. The flag is dropped when reads bring the count back under the threshold. A receive interrupt output is the flag gated by an interrupt-enable bit in the main control register. Writing a one to the flush bit of the buffer control register empties the buffer at once. The fill count is also available directly as an output.

Top module: `rx_trigger_fifo`

## Requirements
- R1: After reset the buffer is empty: fill count 0, ready flag 0, interrupt 0, read data 0x00, threshold code 0. The count never exceeds 16, and bytes are read back in the order they were stored, including across pointer wrap.
- R2: Bits 7:6 of the buffer control register (offset 0x18) choose the threshold. Code 0 means 1 byte, code 1 means 4, code 2 means 8 and code 3 means 14.
- R3: A write to offset 0x18 with bit 1 set clears the count to 0 and clears the ready flag at that clock edge, and any byte offered in the same cycle is dropped. Bit 1 is not stored.
- R4: An offered byte is stored only when the count before the edge is below 16. A byte offered at 16 is discarded, even if a read happens in the same cycle.
- R5: When a byte is stored without a read in the same cycle, the ready flag is set if the new count is at or above the threshold.
- R6: A read of offset 0x14 with a non-empty buffer returns the oldest byte and decrements the count. The ready flag is cleared if the new count is below the threshold.
- R7: `rx_irq` equals the ready flag ANDed with bit 6 of the control register (offset 0x08).
- R8: A read of offset 0x14 while the buffer is empty returns 0xFF and changes neither the count nor the flag.
- R9: A read of offset 0x1C returns the fill count at the edge of the read, zero-extended to 8 bits.
- R10: Offered bytes are ignored while bit 4 of the control register (offset 0x08) is 0.
- R11: When a byte is stored and a data read pops in the same cycle, the count and the ready flag keep their values, and both bytes keep their order.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. A read of any other offset returns 0x00, and a write takes priority over a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is offered |
| rx_data | input | 8 | Received byte |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| fill_level | output | 5 | Current number of stored bytes |
| rx_ready | output | 1 | Threshold-reached flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A byte can be stored and a data read can pop in the same clock cycle. The bench provokes this by raising `rx_valid` and `bus_rd` at offset 0x14 together, once with the buffer full and once with it one below full. In the full case only the pop happens. In the one-below-full case both happen, and the count and flag must hold. The scoreboard model applies the push before the pop to its expected queue, so the order of every later read shows whether both bytes were handled correctly.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

  // register offsets (byte addresses)
  localparam int OFF_CTRL  = 'h08;
  localparam int OFF_DATA  = 'h14;
  localparam int OFF_BCTL  = 'h18;
  localparam int OFF_LEVEL = 'h1C;

  // bit positions
  localparam int CTRL_IE_BIT   = 6;
  localparam int CTRL_RXEN_BIT = 4;
  localparam int BCTL_TRIG_HI  = 7;
  localparam int BCTL_TRIG_LO  = 6;
  localparam int BCTL_FLUSH    = 1;

  // threshold in bytes for a two-bit code
  function automatic int unsigned trig_level(input logic [1:0] code,
                                             input int unsigned depth);
    int unsigned lvl;
    case (code)
      2'd0:    lvl = 1;
      2'd1:    lvl = 4;
      2'd2:    lvl = 8;
      default: lvl = depth - 2;
    endcase
    return lvl;
  endfunction

  // fill count after one edge
  function automatic int unsigned fill_next(input int unsigned cur,
                                            input logic push,
                                            input logic pop);
    int unsigned n;
    n = cur;
    if (push && !pop) n = cur + 1;
    else if (pop && !push) n = cur - 1;
    return n;
  endfunction

  // ring pointer advance
  function automatic int unsigned ring_next(input int unsigned p,
                                            input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // ready flag after one edge
  function automatic logic flag_next(input logic cur, input int unsigned cnt,
                                     input int unsigned lvl, input logic push,
                                     input logic pop, input logic flush);
    logic f;
    f = cur;
    if (flush) f = 1'b0;
    else if (push && !pop) begin
      if (cnt + 1 >= lvl) f = 1'b1;
    end else if (pop && !push) begin
      if (cnt - 1 < lvl) f = 1'b0;
    end
    return f;
  endfunction

endpackage

// File: rtl/rxq_ctl_regs.sv
`timescale 1ns/1ps
module rxq_ctl_regs
  import rxq_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          irq_en,
  output logic          rx_en,
  output logic [1:0]    trig_code,
  output logic          flush
);

  logic wr_ctrl, wr_bctl;
  logic unused_wdata;

  assign wr_ctrl = bus_wr && (bus_addr == AW'(OFF_CTRL));
  assign wr_bctl = bus_wr && (bus_addr == AW'(OFF_BCTL));
  assign flush   = wr_bctl && bus_wdata[BCTL_FLUSH];
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= 1'b0;
      rx_en     <= 1'b0;
      trig_code <= 2'd0;
    end else begin
      if (wr_ctrl) begin
        irq_en <= bus_wdata[CTRL_IE_BIT];
        rx_en  <= bus_wdata[CTRL_RXEN_BIT];
      end
      if (wr_bctl) trig_code <= bus_wdata[BCTL_TRIG_HI:BCTL_TRIG_LO];
    end
  end

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bctl |=> $stable(trig_code)); // R2

endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       flush,
  input  logic [DW-1:0]              din,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ring_next(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ring_next(32'(rd_ptr), DEPTH));
      count <= CW'(fill_next(32'(count), push, pop));
    end
  end

  assign dout = mem[rd_ptr];

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH); // R1
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(count) == DEPTH && !pop && !flush) |=> 32'(count) == DEPTH); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0); // R3
  AST_BOTH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush) |=> $stable(count)); // R11

endmodule

// File: rtl/rxq_ready_flag.sv
`timescale 1ns/1ps
module rxq_ready_flag
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       flush,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [1:0]                 trig_code,
  output logic                       ready
);

  int unsigned lvl;
  logic        reached_after_push;
  logic        under_after_pop;

  assign lvl = trig_level(trig_code, DEPTH);
  // events brought out for the checks
  assign reached_after_push = push && !pop && !flush && (32'(count) >= lvl - 1);
  assign under_after_pop    = pop && !push && !flush && (32'(count) <= lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) ready <= 1'b0;
    else        ready <= flag_next(ready, 32'(count), lvl, push, pop, flush);
  end

  AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    reached_after_push |=> ready); // R5
  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    under_after_pop |=> !ready); // R6
  AST_FLAG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ready); // R3
  AST_FLAG_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush) |=> $stable(ready)); // R11

endmodule

// File: rtl/rx_trigger_fifo.sv
`timescale 1ns/1ps
module rx_trigger_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [DW-1:0]              rx_data,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [AW-1:0]              bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  output logic [DW-1:0]              bus_rdata,
  output logic [$clog2(DEPTH+1)-1:0] fill_level,
  output logic                       rx_ready,
  output logic                       rx_irq
);

  localparam int CW = $clog2(DEPTH+1);

  logic          irq_en, rx_en, flush;
  logic [1:0]    trig_code;
  logic          rd_any, rd_data_req, rd_level_req;
  logic          push_ok, pop_ok;
  logic [DW-1:0] head_byte;
  logic [CW-1:0] count;

  rxq_ctl_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_en(irq_en), .rx_en(rx_en),
    .trig_code(trig_code), .flush(flush)
  );

  assign rd_any       = bus_rd && !bus_wr;
  assign rd_data_req  = rd_any && (bus_addr == AW'(OFF_DATA));
  assign rd_level_req = rd_any && (bus_addr == AW'(OFF_LEVEL));
  assign push_ok      = rx_valid && rx_en && (32'(count) < DEPTH) && !flush;
  assign pop_ok       = rd_data_req && (count != '0);

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok), .flush(flush),
    .din(rx_data), .dout(head_byte), .count(count)
  );

  rxq_ready_flag #(.DEPTH(DEPTH)) u_flag (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok), .flush(flush),
    .count(count), .trig_code(trig_code), .ready(rx_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      if (rd_data_req)       bus_rdata <= (count != '0) ? head_byte : '1;
      else if (rd_level_req) bus_rdata <= DW'(count);
      else                   bus_rdata <= '0;
    end
  end

  assign fill_level = count;
  assign rx_irq     = rx_ready && irq_en;

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_req && count == '0) |=> (bus_rdata == '1 && count == '0)); // R8
  AST_LEVEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_level_req |=> bus_rdata == DW'($past(count))); // R9
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_en && !rd_data_req && !flush) |=> $stable(count)); // R10
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_ready); // R7

endmodule

// File: tb/rx_trigger_fifo_bench.sv
`timescale 1ns/1ps
module rx_trigger_fifo_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, bus_wr, bus_rd;
  logic [7:0] rx_data, bus_wdata, bus_rdata;
  logic [5:0] bus_addr;
  logic [4:0] fill_level;
  logic       rx_ready, rx_irq;

  always #5 clk = ~clk;

  rx_trigger_fifo u_rx_trigger_fifo (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fill_level(fill_level), .rx_ready(rx_ready), .rx_irq(rx_irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model
  logic [7:0] mq[$];
  int  m_trig = 1;
  bit  m_flag = 0, m_en = 0, m_ie = 0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after each read
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, int'(bus_rdata), int'(e.v));
    end
  end

  function automatic int code_lvl(int code);
    case (code) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  task automatic write_reg(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
    if (a == 6'h08) begin m_ie = d[6]; m_en = d[4]; end
    if (a == 6'h18) begin
      m_trig = code_lvl(int'(d[7:6]));
      if (d[1]) begin mq.delete(); m_flag = 0; end
    end
  endtask

  task automatic offer(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 0;
    if (m_en && mq.size() < 16) begin
      mq.push_back(b);
      if (mq.size() >= m_trig) m_flag = 1;
    end
  endtask

  // optional byte offered together with the read
  task automatic read_reg(logic [5:0] a, string tag, bit with_push, logic [7:0] b);
    exp_t e;
    bit acc, pp;
    @(negedge clk);
    bus_rd = 1; bus_addr = a; rx_valid = with_push; rx_data = b;
    @(posedge clk); #1;
    bus_rd = 0; rx_valid = 0;
    acc = with_push && m_en && mq.size() < 16;
    pp  = (a == 6'h14) && mq.size() > 0;
    e.tag = tag;
    if (a == 6'h14)      e.v = pp ? mq[0] : 8'hFF;
    else if (a == 6'h1C) e.v = 8'(mq.size());
    else                 e.v = 8'h00;
    if (acc) mq.push_back(b);
    if (pp)  void'(mq.pop_front());
    if (acc && !pp && mq.size() >= m_trig) m_flag = 1;
    if (pp && !acc && mq.size() < m_trig)  m_flag = 0;
    exp_q.push_back(e);
  endtask

  task automatic check_status(string tag);
    @(negedge clk);
    check({tag, " ready"}, int'(rx_ready), int'(m_flag));
    check({tag, " irq"},   int'(rx_irq),   int'(m_flag && m_ie));
    check({tag, " level"}, int'(fill_level), mq.size());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; rx_valid = 0; bus_wr = 0; bus_rd = 0;
    rx_data = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    check_status("R1 reset");
    check("R1 rdata reset", int'(bus_rdata), 0);
    read_reg(6'h1C, "R9 level after reset", 0, 0);

    // R8: empty read
    read_reg(6'h14, "R8 empty read", 0, 0);
    check_status("R8 no change");

    // R10: receive disabled
    offer(8'h11);
    check_status("R10 disabled ignored");

    // R5 R6 R7 at threshold 1
    write_reg(6'h08, 8'h50);
    offer(8'hA5);
    check_status("R5 R7 threshold 1");
    read_reg(6'h14, "R6 first byte", 0, 0);
    check_status("R6 flag cleared");

    // R7: interrupt gated off
    write_reg(6'h08, 8'h10);
    offer(8'h5A);
    check_status("R7 gated off");
    write_reg(6'h08, 8'h50);
    check_status("R7 gated on");

    // R2 R3: flush plus threshold code 1 (4 bytes)
    write_reg(6'h18, 8'h42);
    check_status("R3 flush");
    for (int i = 0; i < 3; i++) offer(8'h20 + 8'(i));
    check_status("R2 below 4");
    offer(8'h23);
    check_status("R2 R5 at 4");
    read_reg(6'h14, "R6 oldest at code 1", 0, 0);
    check_status("R6 under 4");

    // R2 code 2 (8 bytes)
    write_reg(6'h18, 8'h82);
    for (int i = 0; i < 7; i++) offer(8'h40 + 8'(i));
    check_status("R2 below 8");
    offer(8'h47);
    check_status("R2 at 8");

    // R2 R4: code 3 (14 bytes), fill to full
    write_reg(6'h18, 8'hC2);
    for (int i = 0; i < 13; i++) offer(8'h30 + 8'(i));
    check_status("R2 below 14");
    offer(8'h3D);
    check_status("R2 R5 at 14");
    offer(8'h3E);
    offer(8'h3F);
    offer(8'hEE);
    check_status("R4 drop at full");
    read_reg(6'h1C, "R9 level full", 0, 0);

    // R11 R4: push with pop at full, then at 15
    read_reg(6'h14, "R4 full pop with push", 1, 8'h77);
    check_status("R4 push dropped");
    read_reg(6'h14, "R11 push and pop", 1, 8'h78);
    check_status("R11 count held");

    // R1 R6: drain with wrap, order
    for (int i = 0; i < 15; i++) read_reg(6'h14, "R1 R6 drain order", 0, 0);
    check_status("R6 drained");
    read_reg(6'h14, "R8 empty after drain", 0, 0);

    // R12: unmapped offset, write priority
    read_reg(6'h04, "R12 unmapped", 0, 0);
    read_reg(6'h1C, "R12 level after unmapped", 0, 0);

    // R3: flush with data present
    write_reg(6'h18, 8'h00);
    for (int i = 0; i < 3; i++) offer(8'h90 + 8'(i));
    check_status("R3 before flush");
    write_reg(6'h18, 8'h02);
    check_status("R3 after flush");
    read_reg(6'h14, "R3 empty after flush", 0, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule